// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches three external interrupt lines and raises a sticky request flag for each one when the selected transition occurs. Line A has a two-bit mode that selects rising, falling or both edges, or turns the line off. Line A also goes through a level filter, so short glitches are ignored. Line B has a one-bit rising/falling select. Line C reacts to both edges. Line C is captured by storage elements clocked by the pin itself, so a transition is recorded even when the system clock is slow or stopped.

The two mode fields sit in a small register that loads on a write strobe. Software or the interrupt controller clears a flag with a one-cycle pulse on that flag's clear bit. A wake output goes high as soon as line C moves, with no clock needed, and stays high until the line-C flag is cleared. The core uses this output to leave its halt or stop standby states.

Top module: `ext_irq_edge`

## Requirements
- R1: After reset all request flags are 0 and wake_o is 0.
- R2: Line A mode codes: 2'b00 detects rising edges, 2'b01 falling edges, 2'b10 both edges, 2'b11 turns the line off (no flag is ever set).
- R3: The filtered level of line A changes only after the synchronized input has held the new level for 3 consecutive clock samples. A pulse of 1 or 2 samples never sets flag 0.
- R4: A held change on irq_a_i that is first sampled at clock edge m sets req_o[0] at edge m+4, and not earlier.
- R5: Line B mode bit 0 detects rising edges and 1 detects falling edges. A change first sampled at edge m sets req_o[1] at edge m+2.
- R6: Line C sets req_o[2] on any transition, including a pulse shorter than one clock period. A transition before edge m sets the flag at edge m+2.
- R7: wake_o rises without any clock edge when irq_c_i changes. It stays high while a line-C event is pending or req_o[2] is set, and falls once the flag is cleared.
- R8: Each flag stays set until its clr_i bit is pulsed. If a new event and a clear arrive in the same cycle, the flag stays set.
- R9: Changing a mode never creates an edge. While line A is off its edge tracking continues, so turning it back on with the pin already at a new level sets no flag.
- R10: cfg_we_i loads cfg_a_i and cfg_b_i, and the new modes take effect from the next edge. Reset selects rising-edge mode for both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_a_i | input | 1 | Filtered interrupt line with four-way mode |
| irq_b_i | input | 1 | Interrupt line with rising/falling select |
| irq_c_i | input | 1 | Asynchronous both-edge interrupt line |
| cfg_we_i | input | 1 | Load strobe for the mode register |
| cfg_a_i | input | 2 | New mode for line A |
| cfg_b_i | input | 1 | New mode for line B |
| clr_i | input | 3 | Per-flag clear pulses |
| req_o | output | 3 | Sticky request flags, bit k for line A/B/C |
| wake_o | output | 1 | Standby release from line C |

## Verification
The assertions assume that clr_i and cfg_we_i are driven synchronously to clk_i. They also assume that lines A and B change at most once per clock. Line C is the only input allowed to move freely between edges. The stimulus drives every synchronous input at the falling clock edge. Line C sometimes toggles twice within one half period, so the bench covers pulses shorter than a clock. Lines A and B stay low during reset, so no edge is pending when reset is released.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;

  localparam int unsigned NUM_LINES = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic filt_o,
  output logic upd_o
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic          filt_q;
  logic [CW-1:0] cnt_q;

  // level accepted on the HOLD-th consecutive differing sample
  assign upd_o  = (in_i != filt_q) && (cnt_q == CW'(HOLD - 1));
  assign filt_o = filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (in_i == filt_q) begin
      cnt_q  <= '0;
    end else if (upd_o) begin
      filt_q <= in_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(in_i) == filt_q)); // R3
endmodule

// File: rtl/irq_async_toggle.sv
module irq_async_toggle #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o,
  output logic pend_o
);
  logic       tog_r_q, tog_f_q;
  logic [1:0] tog_sync, seen_q;

  // pin-clocked capture: works with the system clock stopped
  always_ff @(posedge pin_i or negedge rst_ni) begin
    if (!rst_ni) tog_r_q <= 1'b0;
    else         tog_r_q <= ~tog_r_q;
  end

  always_ff @(negedge pin_i or negedge rst_ni) begin
    if (!rst_ni) tog_f_q <= 1'b0;
    else         tog_f_q <= ~tog_f_q;
  end

  irq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tog_r_q, tog_f_q}),
    .q_o   (tog_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= tog_sync;
  end

  assign edge_o = |(tog_sync ^ seen_q);
  assign pend_o = |({tog_r_q, tog_f_q} ^ seen_q);
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_HOLD   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_a_i,
  input  logic       irq_b_i,
  input  logic       irq_c_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_a_i,
  input  logic       cfg_b_i,
  input  logic [2:0] clr_i,
  output logic [2:0] req_o,
  output logic       wake_o
);
  edge_mode_e           mode_a_q;
  logic                 mode_b_q;
  logic [1:0]           ab_sync;
  logic                 a_filt, a_upd;
  logic                 prev_b_q;
  logic                 c_edge, c_pend;
  logic [NUM_LINES-1:0] set_vec, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_a_q <= EDGE_RISE;
      mode_b_q <= 1'b0;
    end else if (cfg_we_i) begin
      mode_a_q <= edge_mode_e'(cfg_a_i);
      mode_b_q <= cfg_b_i;
    end
  end

  irq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync_ab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({irq_b_i, irq_a_i}),
    .q_o   (ab_sync)
  );

  irq_glitch_filter #(.HOLD(FILT_HOLD)) u_filt_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (ab_sync[0]),
    .filt_o(a_filt),
    .upd_o (a_upd)
  );

  // B tracks regardless of mode so mode writes cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_b_q <= 1'b0;
    else         prev_b_q <= ab_sync[1];
  end

  irq_async_toggle #(.SYNC_STAGES(SYNC_STAGES)) u_async_c (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (irq_c_i),
    .edge_o(c_edge),
    .pend_o(c_pend)
  );

  always_comb begin
    unique case (mode_a_q)
      EDGE_RISE: set_vec[0] = a_upd & ~a_filt;
      EDGE_FALL: set_vec[0] = a_upd &  a_filt;
      EDGE_BOTH: set_vec[0] = a_upd;
      default:   set_vec[0] = 1'b0;
    endcase
    set_vec[1] = mode_b_q ? (prev_b_q & ~ab_sync[1]) : (~prev_b_q & ab_sync[1]);
    set_vec[2] = c_edge;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & ~clr_i) | set_vec;
  end

  assign req_o  = req_q;
  assign wake_o = req_q[2] | c_pend;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_q[k] && !clr_i[k]) |=> req_q[k]); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[k] |=> req_q[k]); // R8
  end

  AST_OFF_STAYS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_a_q == EDGE_OFF && !req_q[0]) |=> !req_q[0]); // R2

  AST_WAKE_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q[2] |-> wake_o); // R7
endmodule

// File: tb/ext_irq_edge_test.sv
module ext_irq_edge_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_a = 2'b00;
  logic       cfg_b = 1'b0;
  logic [2:0] clr = 3'b000;
  logic [2:0] req;
  logic       wake;

  int checks = 0, fails = 0;
  int crise = 0, cfall = 0;
  bit mon_on = 0, done = 0;

  always #5 clk = ~clk;

  ext_irq_edge uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .irq_a_i(pin_a), .irq_b_i(pin_b), .irq_c_i(pin_c),
    .cfg_we_i(cfg_we), .cfg_a_i(cfg_a), .cfg_b_i(cfg_b),
    .clr_i(clr), .req_o(req), .wake_o(wake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_c(input logic v);
    if (v != pin_c) begin
      if (v) crise++; else cfall++;
      pin_c = v;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] a, input logic b);
    @(negedge clk); cfg_a = a; cfg_b = b; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = 3'b000;
  endtask

  // behavioural reference, stepped just after each rising edge
  int a1, a2, fa, run, b1, b2, b3, r1, r2, rseen, f1, f2, fseen, ma, mb;
  int mreq [3];

  initial begin
    a1 = 0; a2 = 0; fa = 0; run = 0; b1 = 0; b2 = 0; b3 = 0;
    r1 = 0; r2 = 0; rseen = 0; f1 = 0; f2 = 0; fseen = 0; ma = 0; mb = 0;
    for (int i = 0; i < 3; i++) mreq[i] = 0;
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && !done) begin
        int x, set0, set1, set2, rt, ft, exp_wake;
        bit rose;
        rt = crise & 1; ft = cfall & 1;
        set0 = 0;
        x = a2;
        if (x != fa) begin
          run++;
          if (run == 3) begin
            rose = (x == 1);
            fa = x; run = 0;
            if (ma == 0) set0 = rose;
            else if (ma == 1) set0 = !rose;
            else if (ma == 2) set0 = 1;
          end
        end else run = 0;
        set1 = (mb == 0) ? (b2 == 1 && b3 == 0) : (b2 == 0 && b3 == 1);
        b3 = b2; b2 = b1; b1 = pin_b;
        set2 = (r2 != rseen) || (f2 != fseen);
        rseen = r2; r2 = r1; r1 = rt;
        fseen = f2; f2 = f1; f1 = ft;
        mreq[0] = (mreq[0] && !clr[0]) || set0;
        mreq[1] = (mreq[1] && !clr[1]) || set1;
        mreq[2] = (mreq[2] && !clr[2]) || set2;
        if (cfg_we) begin ma = cfg_a; mb = cfg_b; end
        a2 = a1; a1 = pin_a;
        exp_wake = mreq[2] || (rt != rseen) || (ft != fseen);
        check(req[0] == mreq[0], "R2 R3 R4 R8 R9 R10 flag A", req[0], mreq[0]);
        check(req[1] == mreq[1], "R5 R8 flag B", req[1], mreq[1]);
        check(req[2] == mreq[2], "R6 R8 flag C", req[2], mreq[2]);
        check(wake == exp_wake, "R7 wake", wake, exp_wake);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    mon_on = 1;
    #1;
    check(req == 3'b000, "R1 reset flags", req, 0);
    check(wake == 1'b0, "R1 reset wake", wake, 0);

    // R4 / R10: default rising mode, exact latency
    @(negedge clk); pin_a = 1'b1;
    cyc(4);
    check(req[0] == 1'b0, "R4 not before edge m+4", req[0], 0);
    cyc(1);
    check(req[0] == 1'b1, "R10 default rising mode", req[0], 1);
    pulse_clr(3'b001);
    check(req[0] == 1'b0, "R8 clear", req[0], 0);

    // R3: glitch filtered in both-edge mode
    write_cfg(2'b10, 1'b0);
    @(negedge clk); pin_a = 1'b0;
    cyc(2); pin_a = 1'b1;
    cyc(8);
    check(req[0] == 1'b0, "R3 two-sample glitch", req[0], 0);
    pin_a = 1'b0;
    cyc(3); pin_a = 1'b1;
    cyc(8);
    check(req[0] == 1'b1, "R3 three-sample pulse", req[0], 1);
    pulse_clr(3'b001);

    // R2 falling, R9 off then back on
    write_cfg(2'b01, 1'b0);
    @(negedge clk); pin_a = 1'b0;
    cyc(6);
    check(req[0] == 1'b1, "R2 falling mode", req[0], 1);
    pulse_clr(3'b001);
    write_cfg(2'b11, 1'b0);
    @(negedge clk); pin_a = 1'b1;
    cyc(6);
    check(req[0] == 1'b0, "R9 off mode ignores edge", req[0], 0);
    write_cfg(2'b00, 1'b0);
    cyc(6);
    check(req[0] == 1'b0, "R9 no edge on re-enable", req[0], 0);

    // R5 line B
    @(negedge clk); pin_b = 1'b1;
    cyc(3);
    check(req[1] == 1'b1, "R5 rising", req[1], 1);
    cyc(10);
    check(req[1] == 1'b1, "R8 sticky", req[1], 1);
    pulse_clr(3'b010);
    write_cfg(2'b00, 1'b1);
    @(negedge clk); pin_b = 1'b0;
    cyc(3);
    check(req[1] == 1'b1, "R5 falling", req[1], 1);
    pulse_clr(3'b010);
    @(negedge clk); pin_b = 1'b1;
    cyc(4);
    check(req[1] == 1'b0, "R5 rise ignored in falling mode", req[1], 0);

    // R6 / R7 short pulse on line C
    @(negedge clk); set_c(1'b1);
    #2 set_c(1'b0);
    #1;
    check(wake == 1'b1, "R7 wake without clock", wake, 1);
    check(req[2] == 1'b0, "R6 not yet set", req[2], 0);
    cyc(4);
    check(req[2] == 1'b1, "R6 short pulse caught", req[2], 1);
    pulse_clr(3'b100);
    #1;
    check(wake == 1'b0, "R7 wake released", wake, 0);

    // mixed traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      clr = 3'b000; cfg_we = 1'b0;
      if ($urandom_range(5) == 0) pin_a = ~pin_a;
      if ($urandom_range(3) == 0) pin_b = ~pin_b;
      for (int k = 0; k < 3; k++) if ($urandom_range(7) == 0) clr[k] = 1'b1;
      if ($urandom_range(15) == 0) begin
        cfg_we = 1'b1; cfg_a = 2'($urandom_range(3)); cfg_b = 1'($urandom_range(1));
      end
      case ($urandom_range(9))
        0, 1: set_c(~pin_c);
        2: begin set_c(~pin_c); #2 set_c(~pin_c); end
        default: ;
      endcase
    end
    @(negedge clk); clr = 3'b000; cfg_we = 1'b0;
    cyc(2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule